// File: doc/BRIEF.md
# Execute-Stage Operand Bypass Selector

This block sits in front of the ALU in a five-stage in-order pipeline. For each ALU operand it decides where the operand comes from. There are three sources:

- the value read from the register file during decode;
- the result waiting in the register between execute and memory, a one-instruction distance;
- the value waiting in the register between memory and writeback, a two-instruction distance.

The block is purely combinational. It compares the operand's source register number against the destination numbers and write enables of the two older in-flight instructions. It drives the chosen value together with a select code that the rest of the datapath can observe.

The nearer bypass lets back-to-back dependent instructions run with no stall. The farther one covers a producer and consumer that have one unrelated instruction between them, which saves one cycle. This also covers a load or store whose base register was just produced, so the address add uses the fresh base value.

A load sitting in the memory stage has no data yet. When it targets the operand's register, the selector does not bypass and shows the register-file code. Stalling that consumer is left to the hazard unit.

Top module: `opnd_bypass`

## Requirements
- R1: With no qualifying match for an operand, its select code is 0 and its output equals the register-file value. Select code 3 never appears.
- R2: A memory-stage instruction qualifies for an operand when all of these hold: its write enable is set, its destination is nonzero, its destination equals the operand's source, and it is not a load. A qualifying memory-stage instruction gives select code 1 and outputs the memory-stage result.
- R3: A writeback-stage match needs the write enable set, a nonzero destination, and a destination equal to the operand's source. When the memory stage does not also write that register, such a match gives select code 2 and outputs the writeback value.
- R4: When both older stages write the operand's register and the memory-stage instruction is not a load, the memory stage wins and the select code is 1.
- R5: A destination of register 0 never produces a bypass from either stage, even when the source is also register 0.
- R6: A stage whose write enable is clear never produces a bypass, whatever its destination.
- R7: When the memory-stage instruction is a load writing the operand's register, the select code is 0 and the register-file value is output. This holds even if the writeback stage also matches.
- R8: Each operand is resolved on its own. Two operands in the same cycle may take different sources.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_src | input | NOPS x AW | Source register number for each operand of the instruction in execute |
| rf_data | input | NOPS x XLEN | Register-file value read in decode, one per operand |
| mem_wen | input | 1 | Memory-stage instruction writes a register |
| mem_is_load | input | 1 | Memory-stage instruction is a load |
| mem_rd | input | AW | Memory-stage destination register |
| mem_result | input | XLEN | ALU result held after execute |
| wb_wen | input | 1 | Writeback-stage instruction writes a register |
| wb_rd | input | AW | Writeback-stage destination register |
| wb_data | input | XLEN | Value held before writeback |
| opnd | output | NOPS x XLEN | Selected operand per ALU input |
| sel | output | NOPS x 2 | Source code per operand: 0 register file, 1 memory stage, 2 writeback stage |

## Verification
The bench builds the block with its defaults: a 32-bit data path, 32 registers and two operands. With those values, the full comparator width and both operand lanes are covered. Random register numbers are drawn mostly from registers 0 to 3. That makes stage collisions, register-0 destinations and the load-shadow case frequent rather than rare. The priority of the memory stage over the writeback stage is therefore exercised many times in both operand lanes.

// File: rtl/opnd_bypass_pkg.sv
package opnd_bypass_pkg;

  typedef enum logic [1:0] {
    SRC_REGFILE  = 2'd0,
    SRC_MEMSTAGE = 2'd1,
    SRC_WBSTAGE  = 2'd2
  } src_sel_e;

endpackage

// File: rtl/bypass_match.sv
module bypass_match #(
  parameter int AW = 5
) (
  input  logic          wen,
  input  logic [AW-1:0] rd,
  input  logic [AW-1:0] src,
  output logic          hit
);

  // A stage can supply a value only if it really writes a non-zero register
  function automatic logic dest_claims(input logic w, input logic [AW-1:0] d,
                                       input logic [AW-1:0] s);
    return w && (d != '0) && (d == s);
  endfunction

  assign hit = dest_claims(wen, rd, src);

endmodule

// File: rtl/bypass_pick.sv
module bypass_pick
  import opnd_bypass_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            mem_hit,
  input  logic            mem_is_load,
  input  logic            wb_hit,
  input  logic [XLEN-1:0] rf_val,
  input  logic [XLEN-1:0] mem_val,
  input  logic [XLEN-1:0] wb_val,
  output logic [XLEN-1:0] opnd,
  output src_sel_e        sel
);

  // Younger stage has priority; a load in memory shadows the older copy
  function automatic src_sel_e choose(input logic mh, input logic ml, input logic wh);
    if (mh) return ml ? SRC_REGFILE : SRC_MEMSTAGE;
    if (wh) return SRC_WBSTAGE;
    return SRC_REGFILE;
  endfunction

  always_comb begin
    sel = choose(mem_hit, mem_is_load, wb_hit);
    unique case (sel)
      SRC_MEMSTAGE: opnd = mem_val;
      SRC_WBSTAGE:  opnd = wb_val;
      default:      opnd = rf_val;
    endcase
  end

endmodule

// File: rtl/opnd_bypass.sv
module opnd_bypass
  import opnd_bypass_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int REGS = 32,
  parameter int NOPS = 2,
  localparam int AW  = $clog2(REGS)
) (
  input  logic [NOPS-1:0][AW-1:0]   ex_src,
  input  logic [NOPS-1:0][XLEN-1:0] rf_data,
  input  logic                      mem_wen,
  input  logic                      mem_is_load,
  input  logic [AW-1:0]             mem_rd,
  input  logic [XLEN-1:0]           mem_result,
  input  logic                      wb_wen,
  input  logic [AW-1:0]             wb_rd,
  input  logic [XLEN-1:0]           wb_data,
  output logic [NOPS-1:0][XLEN-1:0] opnd,
  output logic [NOPS-1:0][1:0]      sel
);

  // Named per-operand match events, observed by the checker
  logic [NOPS-1:0] mem_hit;
  logic [NOPS-1:0] wb_hit;

  for (genvar i = 0; i < NOPS; i++) begin : g_op
    src_sel_e pick_sel;

    bypass_match #(.AW(AW)) u_mem_match (
      .wen (mem_wen),
      .rd  (mem_rd),
      .src (ex_src[i]),
      .hit (mem_hit[i])
    );

    bypass_match #(.AW(AW)) u_wb_match (
      .wen (wb_wen),
      .rd  (wb_rd),
      .src (ex_src[i]),
      .hit (wb_hit[i])
    );

    bypass_pick #(.XLEN(XLEN)) u_pick (
      .mem_hit     (mem_hit[i]),
      .mem_is_load (mem_is_load),
      .wb_hit      (wb_hit[i]),
      .rf_val      (rf_data[i]),
      .mem_val     (mem_result),
      .wb_val      (wb_data),
      .opnd        (opnd[i]),
      .sel         (pick_sel)
    );

    assign sel[i] = pick_sel;
  end

endmodule

// File: rtl/opnd_bypass_chk.sv
module opnd_bypass_chk #(
  parameter int XLEN = 32,
  parameter int NOPS = 2,
  parameter int AW   = 5
) (
  input logic [NOPS-1:0][AW-1:0]   ex_src,
  input logic [NOPS-1:0][XLEN-1:0] rf_data,
  input logic                      mem_wen,
  input logic                      mem_is_load,
  input logic [AW-1:0]             mem_rd,
  input logic [XLEN-1:0]           mem_result,
  input logic                      wb_wen,
  input logic [AW-1:0]             wb_rd,
  input logic [XLEN-1:0]           wb_data,
  input logic [NOPS-1:0][XLEN-1:0] opnd,
  input logic [NOPS-1:0][1:0]      sel,
  input logic [NOPS-1:0]           mem_hit,
  input logic [NOPS-1:0]           wb_hit
);

  always_comb begin
    for (int i = 0; i < NOPS; i++) begin
      a_r1_regfile: assert (sel[i] != 2'd0 || opnd[i] == rf_data[i])
        else $error("R1 register-file path value mismatch");
      a_r1_code: assert (sel[i] != 2'd3)
        else $error("R1 illegal select code");
      a_r2_mem: assert (!(mem_hit[i] && !mem_is_load) ||
                        (sel[i] == 2'd1 && opnd[i] == mem_result))
        else $error("R2 memory bypass not taken");
      a_r3_wb: assert (!(wb_hit[i] && !mem_hit[i]) ||
                       (sel[i] == 2'd2 && opnd[i] == wb_data))
        else $error("R3 writeback bypass not taken");
      a_r4_prio: assert (!(sel[i] == 2'd2) || !mem_hit[i])
        else $error("R4 older stage beat younger");
      a_r5_zero: assert ((sel[i] != 2'd1 || mem_rd != '0) &&
                         (sel[i] != 2'd2 || wb_rd != '0))
        else $error("R5 bypass from register zero");
      a_r6_wen: assert ((sel[i] != 2'd1 || mem_wen) &&
                        (sel[i] != 2'd2 || wb_wen))
        else $error("R6 bypass without write enable");
      a_r7_load: assert (!(mem_hit[i] && mem_is_load) || sel[i] == 2'd0)
        else $error("R7 load bypassed from memory stage");
      a_r8_lane: assert ((sel[i] != 2'd1 || mem_rd == ex_src[i]) &&
                         (sel[i] != 2'd2 || wb_rd == ex_src[i]))
        else $error("R8 bypass for another lane's register");
    end
  end

endmodule

bind opnd_bypass opnd_bypass_chk #(.XLEN(XLEN), .NOPS(NOPS), .AW(AW)) u_chk (
  .ex_src      (ex_src),
  .rf_data     (rf_data),
  .mem_wen     (mem_wen),
  .mem_is_load (mem_is_load),
  .mem_rd      (mem_rd),
  .mem_result  (mem_result),
  .wb_wen      (wb_wen),
  .wb_rd       (wb_rd),
  .wb_data     (wb_data),
  .opnd        (opnd),
  .sel         (sel),
  .mem_hit     (mem_hit),
  .wb_hit      (wb_hit)
);

// File: tb/opnd_bypass_test.sv
module opnd_bypass_test;
  localparam int XLEN = 32;
  localparam int REGS = 32;
  localparam int NOPS = 2;
  localparam int AW   = $clog2(REGS);

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [NOPS-1:0][AW-1:0]   ex_src;
  logic [NOPS-1:0][XLEN-1:0] rf_data;
  logic                      mem_wen, mem_is_load, wb_wen;
  logic [AW-1:0]             mem_rd, wb_rd;
  logic [XLEN-1:0]           mem_result, wb_data;
  logic [NOPS-1:0][XLEN-1:0] opnd;
  logic [NOPS-1:0][1:0]      sel;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  opnd_bypass #(.XLEN(XLEN), .REGS(REGS), .NOPS(NOPS)) uut (
    .ex_src(ex_src), .rf_data(rf_data), .mem_wen(mem_wen), .mem_is_load(mem_is_load),
    .mem_rd(mem_rd), .mem_result(mem_result), .wb_wen(wb_wen), .wb_rd(wb_rd),
    .wb_data(wb_data), .opnd(opnd), .sel(sel)
  );

  // Expected code: 0 regfile, 1 memory stage, 2 writeback stage
  function automatic logic [1:0] model_sel(input logic [AW-1:0] s);
    logic mem_writes, wb_writes;
    mem_writes = (s != 0) && mem_wen && (mem_rd == s);
    wb_writes  = (s != 0) && wb_wen && (wb_rd == s);
    if (mem_writes && mem_is_load) return 2'd0;
    if (mem_writes) return 2'd1;
    return wb_writes ? 2'd2 : 2'd0;
  endfunction

  function automatic logic [XLEN-1:0] model_val(input int i);
    case (model_sel(ex_src[i]))
      2'd1:    return mem_result;
      2'd2:    return wb_data;
      default: return rf_data[i];
    endcase
  endfunction

  task automatic check_lane(input int i, input string tag);
    logic [1:0] es;
    logic [XLEN-1:0] ev;
    es = model_sel(ex_src[i]);
    ev = model_val(i);
    total++;
    if (sel[i] !== es || opnd[i] !== ev) begin
      bad++;
      $display("FAIL %s lane%0d sel=%0d opnd=%h expected sel=%0d opnd=%h",
               tag, i, sel[i], opnd[i], es, ev);
    end
  endtask

  task automatic apply(input logic [AW-1:0] s0, input logic [AW-1:0] s1,
                       input logic mw, input logic ml, input logic [AW-1:0] mr,
                       input logic ww, input logic [AW-1:0] wr, input string tag);
    @(negedge clk);
    ex_src[0] = s0; ex_src[1] = s1;
    rf_data[0] = 32'h1000_0000 | 32'(s0); rf_data[1] = 32'h2000_0000 | 32'(s1);
    mem_wen = mw; mem_is_load = ml; mem_rd = mr; mem_result = 32'hAAAA_0001;
    wb_wen = ww; wb_rd = wr; wb_data = 32'hBBBB_0002;
    #1;
    check_lane(0, tag);
    check_lane(1, tag);
  endtask

  function automatic string tag_of(input logic [1:0] s);
    case (s)
      2'd1:    return "R2";
      2'd2:    return "R3";
      default: return "R1";
    endcase
  endfunction

  initial begin
    ex_src = '0; rf_data = '0; mem_wen = 0; mem_is_load = 0; mem_rd = '0;
    mem_result = '0; wb_wen = 0; wb_rd = '0; wb_data = '0;
    #2;
    check_lane(0, "R1 idle");
    check_lane(1, "R1 idle");

    apply(5'd6, 5'd7, 1'b1, 1'b0, 5'd3, 1'b1, 5'd4, "R1 no match");
    apply(5'd3, 5'd9, 1'b1, 1'b0, 5'd3, 1'b0, 5'd0, "R2 back-to-back");
    apply(5'd9, 5'd3, 1'b0, 1'b0, 5'd1, 1'b1, 5'd3, "R3 one gap");
    apply(5'd3, 5'd3, 1'b1, 1'b0, 5'd3, 1'b1, 5'd3, "R4 both match");
    apply(5'd0, 5'd0, 1'b1, 1'b0, 5'd0, 1'b1, 5'd0, "R5 reg zero");
    apply(5'd8, 5'd8, 1'b0, 1'b0, 5'd8, 1'b0, 5'd8, "R6 wen clear");
    apply(5'd8, 5'd2, 1'b1, 1'b1, 5'd8, 1'b1, 5'd8, "R7 load shadow");
    apply(5'd8, 5'd2, 1'b1, 1'b0, 5'd8, 1'b1, 5'd2, "R8 split lanes");
    apply(5'd5, 5'd5, 1'b1, 1'b1, 5'd6, 1'b1, 5'd5, "R7 load other reg");

    void'($urandom(32'd2024));
    for (int n = 0; n < 2000; n++) begin
      logic [AW-1:0] r[4];
      for (int k = 0; k < 4; k++)
        r[k] = ($urandom % 4 == 0) ? AW'($urandom) : AW'($urandom % 4);
      @(negedge clk);
      ex_src[0] = r[0]; ex_src[1] = r[1];
      rf_data[0] = $urandom; rf_data[1] = $urandom;
      mem_wen = 1'($urandom); mem_is_load = ($urandom % 4 == 0);
      mem_rd = r[2]; mem_result = $urandom;
      wb_wen = 1'($urandom); wb_rd = r[3]; wb_data = $urandom;
      #1;
      for (int i = 0; i < NOPS; i++) check_lane(i, tag_of(model_sel(ex_src[i])));
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule